// File: doc/BRIEF.md
# DDR Command Address Capture Decoder

This block sits at the device-side entry of a command and address port that runs on a quarter-rate command clock. A small command code is sampled once per clock, on the rising edge of the true clock. The narrow address bus is sampled twice per clock: once on that same rising edge and once on the rising edge of the complement clock. The complement clock arrives as a separate input. The two address halves are joined into one wide address word.

The joined address and the decoded command type together form a registered bundle: a valid flag, the command kind, a 4-bit bank, and a row or column field. The bundle appears at the complement-clock edge that completes the address and stays for one full clock. ACTIVE uses the joined address as bank plus row. READ and WRITE use it as bank plus column. PRECHARGE keeps only the bank. REFRESH keeps nothing. Codes that are not recognised produce no bundle and raise a one-clock illegal flag. Downstream bank logic consumes the bundle without having to deal with the split-edge address.

Top module: `ca_capture_decoder`

## Requirements
- R1: After a synchronous active-low reset, out_valid and out_illegal are 0, out_kind is 0 (NOP), and out_bank and out_rowcol are 0.
- R2: Command codes decode as follows: 3'b111 NOP, 3'b011 ACTIVE, 3'b101 READ, 3'b100 WRITE, 3'b010 PRECHARGE, 3'b001 REFRESH. out_kind reports NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5.
- R3: For ACTIVE, out_bank equals bits [7:4] of the address captured at the true-clock rising edge (the first half). out_rowcol equals {first half bits [3:0], address captured at the next complement-clock rising edge (the second half)}, giving 12 bits.
- R4: For READ and WRITE, out_bank and out_rowcol (taken as the column) are formed from the two halves exactly as in R3.
- R5: For PRECHARGE, out_bank comes from first-half bits [7:4] and out_rowcol is 0. For REFRESH, out_bank and out_rowcol are both 0, whatever the address bus carries.
- R6: The bundle for a command sampled at a true-clock rising edge changes the outputs at the next complement-clock rising edge and holds for exactly one clock. The outputs do not change at the true-clock edge itself.
- R7: For a NOP cycle, out_valid is 0 and out_kind, out_bank and out_rowcol are 0, whatever the address bus carries.
- R8: Codes 3'b000 and 3'b110 give out_valid 0, out_kind 0 (NOP) and fields 0, with out_illegal 1 for that one clock. out_illegal and out_valid are never both 1.
- R9: Commands issued on consecutive clocks each produce their own bundle on consecutive clocks. No address half is mixed between neighbouring commands.
- R10: A reset asserted while a command is being sampled discards that command. The outputs return to the R1 state and the next command after release decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_t | input | 1 | True command clock; command and first address half sampled on its rising edge |
| clk_c | input | 1 | Complement command clock; second address half sampled and bundle registered on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_code | input | 3 | Command code |
| addr_in | input | 8 | Narrow address bus, sampled on both clocks |
| out_valid | output | 1 | Decoded bundle holds a recognised non-NOP command |
| out_illegal | output | 1 | Unrecognised command code seen |
| out_kind | output | 3 | Decoded command kind |
| out_bank | output | 4 | Bank field |
| out_rowcol | output | 12 | Row (ACTIVE) or column (READ/WRITE) field |

## Verification
The two functions that share a cycle are the complement-edge join of one command's second address half and the true-edge capture of the next command's first half. They fall together whenever commands are issued on back-to-back clocks. The bench provokes this by running every command type back to back, with distinct first and second halves on every cycle, so that any half taken from the wrong command changes the bank or row/column. A behavioural model queues the expected bundle for each issued command. That bundle is compared just after the complement edge, and the previous bundle is compared again just after the following true edge, which shows that the outputs moved only on the complement clock.

// File: rtl/ca_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the command/address capture decoder.
// Assumes a 3-bit command code; the code points are fixed here.
package ca_pkg;

    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] CODE_NOP = 3'b111;
    localparam logic [CMD_W-1:0] CODE_ACT = 3'b011;
    localparam logic [CMD_W-1:0] CODE_RD  = 3'b101;
    localparam logic [CMD_W-1:0] CODE_WR  = 3'b100;
    localparam logic [CMD_W-1:0] CODE_PRE = 3'b010;
    localparam logic [CMD_W-1:0] CODE_REF = 3'b001;

    typedef enum logic [2:0] {
        KIND_NOP = 3'd0,
        KIND_ACT = 3'd1,
        KIND_RD  = 3'd2,
        KIND_WR  = 3'd3,
        KIND_PRE = 3'd4,
        KIND_REF = 3'd5
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      illegal;
        logic      keep_bank;
        logic      keep_rowcol;
    } cmd_info_t;

endpackage

// File: rtl/ca_rise_capture.sv
`timescale 1ns/1ps
// Rising-edge capture stage: registers the command code and the first
// address half on the true clock. Assumes rst_n is synchronous to clk_t.
// In reset the stored code is NOP so nothing downstream decodes.
module ca_rise_capture
    import ca_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk_t,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [HALF_W-1:0] addr_in,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [HALF_W-1:0] hi_q
);

    // Sample command and first address half once per clock.
    always_ff @(posedge clk_t) begin
        if (!rst_n) begin
            cmd_q <= CODE_NOP;
            hi_q  <= '0;
        end else begin
            cmd_q <= cmd_code;
            hi_q  <= addr_in;
        end
    end

endmodule

// File: rtl/ca_cmd_decode.sv
`timescale 1ns/1ps
// Combinational command decoder: maps a registered command code to its
// kind and to which address fields the bundle keeps. Unknown codes map
// to NOP with the illegal flag set.
module ca_cmd_decode
    import ca_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_q,
    output cmd_info_t        info
);

    // Translate the code into kind and field-keep flags.
    always_comb begin
        info = '{kind: KIND_NOP, illegal: 1'b0, keep_bank: 1'b0, keep_rowcol: 1'b0};
        case (cmd_q)
            CODE_NOP: info.kind = KIND_NOP;
            CODE_ACT: begin
                info.kind        = KIND_ACT;
                info.keep_bank   = 1'b1;
                info.keep_rowcol = 1'b1;
            end
            CODE_RD: begin
                info.kind        = KIND_RD;
                info.keep_bank   = 1'b1;
                info.keep_rowcol = 1'b1;
            end
            CODE_WR: begin
                info.kind        = KIND_WR;
                info.keep_bank   = 1'b1;
                info.keep_rowcol = 1'b1;
            end
            CODE_PRE: begin
                info.kind      = KIND_PRE;
                info.keep_bank = 1'b1;
            end
            CODE_REF: info.kind = KIND_REF;
            default:  info.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/ca_fall_join.sv
`timescale 1ns/1ps
// Complement-edge join stage: samples the second address half on the
// complement clock, joins it with the first half and the decoded command,
// and registers the output bundle. Assumes clk_c rises half a period after
// clk_t and that rst_n is held across a complement edge to clear it.
module ca_fall_join
    import ca_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int BANK_W = 4,
    localparam int ROWCOL_W = 2*HALF_W - BANK_W
) (
    input  logic                clk_c,
    input  logic                rst_n,
    input  cmd_info_t           info,
    input  logic [HALF_W-1:0]   hi_q,
    input  logic [HALF_W-1:0]   addr_in,
    output logic                out_valid,
    output logic                out_illegal,
    output cmd_kind_e           out_kind,
    output logic [BANK_W-1:0]   out_bank,
    output logic [ROWCOL_W-1:0] out_rowcol
);

    logic [BANK_W-1:0]   bank_field;
    logic [ROWCOL_W-1:0] joined_field;

    // The bank sits in the top bits of the first half.
    assign bank_field = hi_q[HALF_W-1 -: BANK_W];

    // Upper row/column bits exist only when the first half is wider than the bank.
    generate
        if (HALF_W > BANK_W) begin : g_split_upper
            assign joined_field = {hi_q[HALF_W-BANK_W-1:0], addr_in};
        end else begin : g_lower_only
            assign joined_field = addr_in;
        end
    endgenerate

    // Register the bundle at the complement edge that completes the address.
    always_ff @(posedge clk_c) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_kind    <= KIND_NOP;
            out_bank    <= '0;
            out_rowcol  <= '0;
        end else begin
            out_valid   <= !info.illegal && (info.kind != KIND_NOP);
            out_illegal <= info.illegal;
            out_kind    <= info.kind;
            out_bank    <= info.keep_bank   ? bank_field   : '0;
            out_rowcol  <= info.keep_rowcol ? joined_field : '0;
        end
    end

endmodule

// File: rtl/ca_capture_decoder.sv
`timescale 1ns/1ps
// Top of the command/address capture decoder. Commands are taken on the
// true clock; the address is taken on both the true and complement clocks
// and the joined bundle is registered on the complement clock.
// Assumes clk_c is the inverse of clk_t, supplied as its own input.
module ca_capture_decoder
    import ca_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int BANK_W = 4,
    localparam int ROWCOL_W = 2*HALF_W - BANK_W
) (
    input  logic                clk_t,
    input  logic                clk_c,
    input  logic                rst_n,
    input  logic [CMD_W-1:0]    cmd_code,
    input  logic [HALF_W-1:0]   addr_in,
    output logic                out_valid,
    output logic                out_illegal,
    output logic [2:0]          out_kind,
    output logic [BANK_W-1:0]   out_bank,
    output logic [ROWCOL_W-1:0] out_rowcol
);

    logic [CMD_W-1:0]  cmd_q;
    logic [HALF_W-1:0] hi_q;
    cmd_info_t         dec_info;
    cmd_kind_e         kind_q;

    ca_rise_capture #(.HALF_W(HALF_W)) u_rise (
        .clk_t    (clk_t),
        .rst_n    (rst_n),
        .cmd_code (cmd_code),
        .addr_in  (addr_in),
        .cmd_q    (cmd_q),
        .hi_q     (hi_q)
    );

    ca_cmd_decode u_dec (
        .cmd_q (cmd_q),
        .info  (dec_info)
    );

    ca_fall_join #(.HALF_W(HALF_W), .BANK_W(BANK_W)) u_join (
        .clk_c       (clk_c),
        .rst_n       (rst_n),
        .info        (dec_info),
        .hi_q        (hi_q),
        .addr_in     (addr_in),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_kind    (kind_q),
        .out_bank    (out_bank),
        .out_rowcol  (out_rowcol)
    );

    // Present the kind as a plain vector at the port.
    assign out_kind = kind_q;

endmodule

// File: rtl/ca_capture_checker.sv
`timescale 1ns/1ps
// Property checker for the capture decoder, bound to the top module.
// Samples on the complement clock, where the bundle changes.
module ca_capture_checker
    import ca_pkg::*;
#(
    parameter int BANK_W   = 4,
    parameter int ROWCOL_W = 12
) (
    input logic                clk_c,
    input logic                rst_n,
    input cmd_info_t           dec_info,
    input logic                out_valid,
    input logic                out_illegal,
    input logic [2:0]          out_kind,
    input logic [BANK_W-1:0]   out_bank,
    input logic [ROWCOL_W-1:0] out_rowcol
);

    assert_valid_illegal_excl_R8: assert property (@(posedge clk_c) disable iff (!rst_n)
        !(out_valid && out_illegal));

    assert_idle_fields_zero_R7: assert property (@(posedge clk_c) disable iff (!rst_n)
        !out_valid |-> (out_kind == 3'd0 && out_bank == '0 && out_rowcol == '0));

    assert_kind_in_range_R2: assert property (@(posedge clk_c) disable iff (!rst_n)
        out_valid |-> (out_kind >= 3'd1 && out_kind <= 3'd5));

    assert_refresh_no_fields_R5: assert property (@(posedge clk_c) disable iff (!rst_n)
        (out_valid && out_kind == 3'd5) |-> (out_bank == '0 && out_rowcol == '0));

    assert_precharge_no_rowcol_R5: assert property (@(posedge clk_c) disable iff (!rst_n)
        (out_valid && out_kind == 3'd4) |-> (out_rowcol == '0));

    assert_bundle_follows_decode_R6: assert property (@(posedge clk_c) disable iff (!rst_n)
        $past(rst_n) |-> (out_kind == 3'($past(dec_info.kind))));

endmodule

bind ca_capture_decoder ca_capture_checker #(.BANK_W(BANK_W), .ROWCOL_W(ROWCOL_W)) u_checker (
    .clk_c       (clk_c),
    .rst_n       (rst_n),
    .dec_info    (dec_info),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_kind    (out_kind),
    .out_bank    (out_bank),
    .out_rowcol  (out_rowcol)
);

// File: tb/ca_capture_decoder_bench.sv
`timescale 1ns/1ps
module ca_capture_decoder_bench;

    typedef struct {
        int valid;
        int illegal;
        int kind;
        int bank;
        int rowcol;
    } exp_t;

    logic        clk_t = 1'b0;
    logic        clk_c;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_code = 3'b111;
    logic [7:0]  addr_in = 8'h00;
    logic        out_valid, out_illegal;
    logic [2:0]  out_kind;
    logic [3:0]  out_bank;
    logic [11:0] out_rowcol;

    int checks = 0;
    int errors = 0;
    exp_t  cur = '{0, 0, 0, 0, 0};
    string cur_tag = "R1";
    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk_t = ~clk_t;
    assign clk_c = ~clk_t;

    ca_capture_decoder u_ca_capture_decoder (
        .clk_t(clk_t), .clk_c(clk_c), .rst_n(rst_n),
        .cmd_code(cmd_code), .addr_in(addr_in),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_kind(out_kind),
        .out_bank(out_bank), .out_rowcol(out_rowcol)
    );

    // Behavioural expectation for one command from the requirements.
    function automatic exp_t model(input logic [2:0] code, input logic [7:0] hi,
                                   input logic [7:0] lo, input bit rs);
        exp_t e = '{0, 0, 0, 0, 0};
        int full_rc = int'(hi[3:0]) * 256 + int'(lo);
        if (!rs) return e;
        case (code)
            3'b011: e = '{1, 0, 1, int'(hi[7:4]), full_rc};
            3'b101: e = '{1, 0, 2, int'(hi[7:4]), full_rc};
            3'b100: e = '{1, 0, 3, int'(hi[7:4]), full_rc};
            3'b010: e = '{1, 0, 4, int'(hi[7:4]), 0};
            3'b001: e = '{1, 0, 5, 0, 0};
            3'b111: e = '{0, 0, 0, 0, 0};
            default: e = '{0, 1, 0, 0, 0};
        endcase
        return e;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (int'(out_valid) != cur.valid || int'(out_illegal) != cur.illegal ||
            int'(out_kind) != cur.kind || int'(out_bank) != cur.bank ||
            int'(out_rowcol) != cur.rowcol) begin
            errors++;
            $display("FAIL %s: got valid=%0d illegal=%0d kind=%0d bank=%0h rowcol=%0h expected valid=%0d illegal=%0d kind=%0d bank=%0h rowcol=%0h",
                     tag, out_valid, out_illegal, out_kind, out_bank, out_rowcol,
                     cur.valid, cur.illegal, cur.kind, cur.bank, cur.rowcol);
        end
    endtask

    // One clock: check the previous bundle, drive a command and its two halves.
    task automatic step(input logic [2:0] code, input logic [7:0] hi, input logic [7:0] lo,
                        input bit rs, input string tag);
        @(negedge clk_t);
        #1;
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
        end
        compare(cur_tag);
        #2;
        rst_n = rs;
        cmd_code = code;
        addr_in = hi;
        exp_q.push_back(model(code, hi, lo, rs));
        tag_q.push_back(tag);
        @(posedge clk_t);
        #2;
        compare("R6");
        addr_in = lo;
    endtask

    initial begin
        step(3'b111, 8'h00, 8'h00, 1'b0, "R1");
        step(3'b111, 8'h00, 8'h00, 1'b0, "R1");
        step(3'b111, 8'hFF, 8'hFF, 1'b1, "R7");
        step(3'b011, 8'hA5, 8'h3C, 1'b1, "R3");
        step(3'b111, 8'h5A, 8'hC3, 1'b1, "R6");
        step(3'b011, 8'hFF, 8'hFF, 1'b1, "R3");
        step(3'b011, 8'h00, 8'h01, 1'b1, "R3");
        step(3'b101, 8'h37, 8'h9E, 1'b1, "R4");
        step(3'b100, 8'hC1, 8'h42, 1'b1, "R4");
        step(3'b010, 8'h9F, 8'hEE, 1'b1, "R5");
        step(3'b001, 8'hFF, 8'hFF, 1'b1, "R5");
        step(3'b000, 8'h77, 8'h88, 1'b1, "R8");
        step(3'b110, 8'h12, 8'h34, 1'b1, "R8");
        step(3'b011, 8'h2B, 8'h00, 1'b1, "R2");
        // Back to back: every half differs from its neighbour.
        step(3'b011, 8'h1F, 8'h80, 1'b1, "R9");
        step(3'b101, 8'hE2, 8'h7F, 1'b1, "R9");
        step(3'b100, 8'h4D, 8'hB6, 1'b1, "R9");
        step(3'b110, 8'hB3, 8'h49, 1'b1, "R9");
        step(3'b101, 8'h86, 8'h15, 1'b1, "R9");
        step(3'b010, 8'h6C, 8'hD2, 1'b1, "R9");
        step(3'b100, 8'hF0, 8'h0F, 1'b1, "R9");
        // Reset lands on a READ.
        step(3'b101, 8'hDE, 8'hAD, 1'b0, "R10");
        step(3'b101, 8'h5E, 8'hA1, 1'b1, "R10");
        step(3'b111, 8'h00, 8'h00, 1'b1, "R6");
        step(3'b111, 8'h00, 8'h00, 1'b1, "R7");
        step(3'b111, 8'h00, 8'h00, 1'b1, "R7");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule